// File: doc/BRIEF.md
# Frame Base Address Hand-over with Update Interrupt

This block sits between software and the pixel fetch path of a display controller. Software writes the address of the next frame buffer through a small word-addressed register bus. The value is held in a staging register. It reaches the fetch logic only when the timing generator signals the start of a frame, so a frame is never read from two buffers at once.

Each hand-over sets a status bit. An enable mask selects which status bits may drive the level interrupt line, and software acknowledges by writing ones to a clear register. A handler that reads the masked status and writes that value back to the clear register acknowledges exactly the events it has seen. An event that arrives in the same cycle as the acknowledge is kept.

Register offsets (word addresses): 0 = frame base (a write stages a new address; a read returns the active address), 1 = interrupt enable, 2 = raw status, 3 = masked status, 4 = clear (write-one-to-clear; reads as zero). The hand-over event is status bit 0.

Top module: `fbu_top`

## Requirements
- R1: After a synchronous reset the active base is RESET_BASE (zero by default), the enable mask and raw status are zero, nothing is staged, and irq_o is low.
- R2: A write to offset 0 stages the written address with its two low bits forced to zero. The active base does not change until the next frame-start strobe.
- R3: A frame-start strobe that finds a staged address copies it to the active base on that clock edge, clears the staged flag, and sets status bit 0.
- R4: A frame-start strobe with nothing staged leaves the active base unchanged and sets no status bit.
- R5: irq_o is high exactly when some bit is set in both raw status and the enable mask. It changes on the same edge as the status or mask that causes the change. Offset 3 reads raw AND enable.
- R6: A write to offset 4 clears every status bit written as 1 and leaves every status bit written as 0 unchanged.
- R7: When a hand-over and a clear of status bit 0 fall in the same cycle, bit 0 ends set.
- R8: Writing zero to the enable mask drops irq_o and makes offset 3 read zero, while raw status keeps its bits.
- R9: When a base write coincides with a frame-start strobe, the address staged before that cycle, if any, becomes active. The newly written address stays staged for the following strobe.
- R10: A read strobe presents the addressed register on bus_rdata_o one clock later, zero-extended. Offset 4 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register word offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| frame_start_i | input | 1 | One-cycle frame-start strobe from the timing generator |
| base_addr_o | output | DATA_W | Active frame base address to pixel fetch |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
A vector table pairs staged addresses, including ones with set low bits, with enable masks that do or do not include bit 0. This shows that address alignment, the hold-off until the frame strobe, and masking are independent of one another. Directed cases then place one event against another in the same cycle: a strobe with nothing staged, a strobe against a clear, and a strobe against a new base write. These cases separate a design that drops a hand-over or promotes too early from one that queues correctly. Partial clears and a zero mask with status still set show whether raw status and the interrupt line are kept apart.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] OFS_BASE = 3'd0;
  localparam logic [REG_AW-1:0] OFS_IEN  = 3'd1;
  localparam logic [REG_AW-1:0] OFS_RAW  = 3'd2;
  localparam logic [REG_AW-1:0] OFS_MSK  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_CLR  = 3'd4;
  localparam int SRC_HANDOVER = 0;
endpackage

// File: rtl/fbu_regif.sv
module fbu_regif #(
  parameter int DATA_W = 32,
  parameter int STAT_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic [fbu_pkg::REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0]         active_i,
  input  logic [STAT_W-1:0]         raw_i,
  input  logic [STAT_W-1:0]         en_i,
  output logic                      base_we_o,
  output logic                      en_we_o,
  output logic                      clr_we_o,
  output logic [DATA_W-1:0]         rdata_o
);
  import fbu_pkg::*;

  localparam int PAD_W = DATA_W - STAT_W;

  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign base_we_o = wr_i && (addr_i == OFS_BASE);
  assign en_we_o   = wr_i && (addr_i == OFS_IEN);
  assign clr_we_o  = wr_i && (addr_i == OFS_CLR);

  always_comb begin
    case (addr_i)
      OFS_BASE: rd_mux = active_i;
      OFS_IEN:  rd_mux = {{PAD_W{1'b0}}, en_i};
      OFS_RAW:  rd_mux = {{PAD_W{1'b0}}, raw_i};
      OFS_MSK:  rd_mux = {{PAD_W{1'b0}}, raw_i & en_i};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/fbu_base_dbuf.sv
module fbu_base_dbuf #(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] RESET_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [DATA_W-3:0] wdata_hi_i,
  input  logic              frame_start_i,
  output logic [DATA_W-1:0] active_o,
  output logic              pend_o,
  output logic              take_o
);
  logic [DATA_W-1:0] stage_q;
  logic [DATA_W-1:0] active_q;
  logic              pend_q;
  logic              take;

  assign take = frame_start_i && pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      active_q <= RESET_BASE;
      pend_q   <= 1'b0;
    end else begin
      if (take)  active_q <= stage_q;
      if (we_i) begin
        stage_q <= {wdata_hi_i, 2'b00};
        pend_q  <= 1'b1;
      end else if (take) begin
        pend_q  <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign pend_o   = pend_q;
  assign take_o   = take;
endmodule

// File: rtl/fbu_irq_stat.sv
module fbu_irq_stat #(
  parameter int STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_i,
  input  logic              en_we_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] raw_o,
  output logic [STAT_W-1:0] en_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] raw_q, raw_d;
  logic [STAT_W-1:0] en_q, en_d;
  logic [STAT_W-1:0] clr_mask;
  logic              irq_q;

  always_comb begin
    clr_mask = clr_we_i ? wdata_i : '0;
    raw_d    = (raw_q & ~clr_mask) | set_i;
    en_d     = en_we_i ? wdata_i : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
      en_q  <= en_d;
      irq_q <= |(raw_d & en_d);
    end
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/fbu_top.sv
module fbu_top #(
  parameter int                DATA_W     = 32,
  parameter int                STAT_W     = 4,
  parameter logic [DATA_W-1:0] RESET_BASE = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr_i,
  input  logic                       bus_rd_i,
  input  logic [fbu_pkg::REG_AW-1:0] bus_addr_i,
  input  logic [DATA_W-1:0]          bus_wdata_i,
  output logic [DATA_W-1:0]          bus_rdata_o,
  input  logic                       frame_start_i,
  output logic [DATA_W-1:0]          base_addr_o,
  output logic                       irq_o
);
  import fbu_pkg::*;

  logic              base_we, en_we, clr_we;
  logic              pend, take;
  logic [STAT_W-1:0] raw, en, set_vec;

  fbu_regif #(.DATA_W(DATA_W), .STAT_W(STAT_W)) regif_i (
    .clk(clk), .rst(rst), .wr_i(bus_wr_i), .rd_i(bus_rd_i), .addr_i(bus_addr_i),
    .active_i(base_addr_o), .raw_i(raw), .en_i(en),
    .base_we_o(base_we), .en_we_o(en_we), .clr_we_o(clr_we), .rdata_o(bus_rdata_o)
  );

  fbu_base_dbuf #(.DATA_W(DATA_W), .RESET_BASE(RESET_BASE)) dbuf_i (
    .clk(clk), .rst(rst), .we_i(base_we), .wdata_hi_i(bus_wdata_i[DATA_W-1:2]),
    .frame_start_i(frame_start_i), .active_o(base_addr_o), .pend_o(pend), .take_o(take)
  );

  always_comb begin
    set_vec = '0;
    set_vec[SRC_HANDOVER] = take;
  end

  fbu_irq_stat #(.STAT_W(STAT_W)) stat_i (
    .clk(clk), .rst(rst), .set_i(set_vec), .en_we_i(en_we), .clr_we_i(clr_we),
    .wdata_i(bus_wdata_i[STAT_W-1:0]), .raw_o(raw), .en_o(en), .irq_o(irq_o)
  );
endmodule

// File: rtl/fbu_sva.sv
module fbu_sva #(
  parameter int DATA_W = 32,
  parameter int STAT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              fs,
  input logic              base_we,
  input logic              pend,
  input logic [STAT_W-1:0] raw,
  input logic [STAT_W-1:0] en,
  input logic [DATA_W-1:0] active,
  input logic              irq
);
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst) irq == |(raw & en)); // R5
  AST_HOLD_BASE: assert property (@(posedge clk) disable iff (rst) !fs |=> $stable(active)); // R2
  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst) active[1:0] == 2'b00); // R2
  AST_HANDOVER_SETS: assert property (@(posedge clk) disable iff (rst) (fs && pend) |=> raw[0]); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) (!pend && !raw[0]) |=> !raw[0]); // R4
  AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (rst) (fs && !base_we) |=> !pend); // R9
  AST_REQUEUE: assert property (@(posedge clk) disable iff (rst) base_we |=> pend); // R9
endmodule

bind fbu_top fbu_sva #(.DATA_W(DATA_W), .STAT_W(STAT_W)) sva_i (
  .clk(clk), .rst(rst), .fs(frame_start_i), .base_we(base_we), .pend(pend),
  .raw(raw), .en(en), .active(base_addr_o), .irq(irq_o)
);

// File: tb/fbu_top_tb_top.sv
module fbu_top_tb_top;
  localparam int DW = 32;
  logic clk = 0, rst = 1;
  logic wr = 0, rd = 0, fs = 0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, base;
  logic irq;
  int tests = 0, fails = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  fbu_top dut_i (
    .clk(clk), .rst(rst), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .frame_start_i(fs),
    .base_addr_o(base), .irq_o(irq)
  );

  localparam logic [31:0] V_BASE [4] = '{32'h1000_0000, 32'h2000_0003, 32'h3333_3331, 32'hFFFF_FFFE};
  localparam logic [3:0]  V_EN   [4] = '{4'h1, 4'h0, 4'hF, 4'h2};
  localparam logic        V_IRQ  [4] = '{1'b1, 1'b0, 1'b1, 1'b0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic pulse_fs();
    @(negedge clk); fs = 1;
    @(negedge clk); fs = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] prev;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 base", base, 32'h0);
    chk("R1 irq", {31'b0, irq}, 0);
    bus_rd(3'd1, rv); chk("R1 enable", rv, 0);
    bus_rd(3'd2, rv); chk("R1 raw", rv, 0);
    // R4 strobe with nothing staged
    pulse_fs();
    chk("R4 base", base, 0);
    bus_rd(3'd2, rv); chk("R4 raw", rv, 0);

    // vector table
    for (int i = 0; i < 4; i++) begin
      bus_wr(3'd4, 32'hF);
      bus_wr(3'd1, {28'b0, V_EN[i]});
      prev = base;
      bus_wr(3'd0, V_BASE[i]);
      chk("R2 held", base, prev);
      pulse_fs();
      chk("R3 base", base, V_BASE[i] & 32'hFFFF_FFFC);
      chk("R5 irq", {31'b0, irq}, {31'b0, V_IRQ[i]});
      bus_rd(3'd3, rv); chk("R5 masked", rv, {31'b0, V_IRQ[i]});
      bus_rd(3'd0, rv); chk("R10 base read", rv, V_BASE[i] & 32'hFFFF_FFFC);
    end

    // R6 partial clear
    bus_wr(3'd1, 32'h1);
    bus_wr(3'd4, 32'hE);
    bus_rd(3'd2, rv); chk("R6 zero bit kept", rv, 1);
    chk("R6 irq kept", {31'b0, irq}, 1);
    bus_rd(3'd4, rv); chk("R10 clear reads zero", rv, 0);
    bus_wr(3'd4, 32'h1);
    bus_rd(3'd2, rv); chk("R6 cleared", rv, 0);
    chk("R6 irq low", {31'b0, irq}, 0);

    // R7 set wins over same-cycle clear
    bus_wr(3'd0, 32'h4000_0000);
    @(negedge clk); fs = 1; wr = 1; addr = 3'd4; wdata = 32'h1;
    @(negedge clk); fs = 0; wr = 0;
    bus_rd(3'd2, rv); chk("R7 raw", rv, 1);
    chk("R7 base", base, 32'h4000_0000);

    // R8 zero mask
    bus_wr(3'd1, 32'h0);
    chk("R8 irq", {31'b0, irq}, 0);
    bus_rd(3'd3, rv); chk("R8 masked", rv, 0);
    bus_rd(3'd2, rv); chk("R8 raw kept", rv, 1);

    // R9 write coinciding with strobe
    bus_wr(3'd4, 32'hF);
    bus_wr(3'd0, 32'h5000_0000);
    @(negedge clk); fs = 1; wr = 1; addr = 3'd0; wdata = 32'h6000_0000;
    @(negedge clk); fs = 0; wr = 0;
    chk("R9 old staged active", base, 32'h5000_0000);
    pulse_fs();
    chk("R9 new staged active", base, 32'h6000_0000);
    bus_rd(3'd2, rv); chk("R9 raw", rv, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule